// File: doc/BRIEF.md
# Segmented Instruction Prefetch Queue

This unit sits on the bus side of a processor front end and keeps a small byte queue of upcoming instruction bytes filled ahead of the decoder. It holds a 16-bit code segment and a 16-bit fetch pointer. It combines them into a 20-bit physical byte address by shifting the segment left four bits and adding the pointer. Whenever the queue has room, it requests the memory word that contains that address.

Returned bytes enter a six-entry byte FIFO. The decoder drains the FIFO one byte per valid/ready handshake, and fetching continues while it does. A redirect input supplies a new segment and pointer, discards everything queued and any response arriving in that cycle, and restarts fetching at the new location.

Top module: `pfq_top`

## Requirements
- R1: While and just after reset, `dec_valid_o` is 0 and `mem_req_o` is 1 with `mem_addr_o` = 20'hFFFF0 (reset segment FFFFh, pointer 0000h).
- R2: `mem_addr_o` equals (segment × 16 + pointer) modulo 2^20.
- R3: A request at an even address is raised only when at least 2 queue slots are free. A request at an odd address needs 1 free slot. Once raised, a request stays high with an unchanged address until it is acknowledged or a redirect occurs.
- R4: An acknowledged even-address fetch pushes `mem_rdata_i[7:0]` and then `mem_rdata_i[15:8]`, and advances the pointer by 2.
- R5: An acknowledged odd-address fetch pushes only `mem_rdata_i[15:8]`, advances the pointer by 1, and leaves the next address even.
- R6: Bytes reach `dec_byte_o` in fetch order, one per cycle in which `dec_valid_o` and `dec_ready_i` are both high.
- R7: The queue never holds more than 6 bytes. `dec_valid_o` is high exactly when the queue is non-empty and no redirect is being applied.
- R8: In a cycle with `flush_i` high, any acknowledged data is dropped and no byte is handed out. On the next cycle the queue is empty and `mem_addr_o` is formed from `flush_seg_i` and `flush_off_i`.
- R9: A push and a pop in the same cycle change the occupancy by (bytes pushed − 1).
- R10: The pointer wraps from FFFFh to 0000h inside the same segment, and physical addresses wrap from FFFFFh to 00000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Redirect: empty the queue and load a new fetch location |
| flush_seg_i | input | 16 | New code segment |
| flush_off_i | input | 16 | New fetch pointer |
| mem_req_o | output | 1 | Word fetch request |
| mem_addr_o | output | 20 | Physical byte address of the fetch |
| mem_ack_i | input | 1 | Request accepted, data valid this cycle |
| mem_rdata_i | input | 16 | Word holding the addressed byte (even byte in low lane) |
| dec_valid_o | output | 1 | Queue head byte available |
| dec_byte_o | output | 8 | Queue head byte |
| dec_ready_i | input | 1 | Decoder takes the head byte |

## Verification
The assertions assume that `mem_ack_i` qualifies data only in a cycle with `mem_req_o` high. They also assume that `mem_rdata_i` carries the aligned word that contains `mem_addr_o` in that same cycle. The stimulus builds each response word from the current address at the falling edge. It may raise the acknowledge with or without a pending request, since the design ignores an acknowledge that arrives without one. Redirects are applied with an acknowledge in the same cycle, so the drop path is always exercised. The decoder-ready and acknowledge rates vary by phase, which produces both a full queue and simultaneous push and pop.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned BUS_BYTES = 2;
  typedef logic [7:0] byte_t;
  typedef logic [1:0] lanes_t;  // bytes pushed per cycle: 0..BUS_BYTES
endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  // wraps modulo 2^ADDR_W
  assign addr_o = {seg_i, {SHIFT{1'b0}}} + ADDR_W'(off_i);
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
  import pfq_pkg::*;
#(
  parameter int unsigned SEG_W   = 16,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned CNT_W   = 3,
  parameter logic [SEG_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_OFF = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [SEG_W-1:0] flush_seg_i,
  input  logic [OFF_W-1:0] flush_off_i,
  input  logic             mem_ack_i,
  input  logic [15:0]      mem_rdata_i,
  input  logic [CNT_W-1:0] free_i,
  input  logic             addr_lsb_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [OFF_W-1:0] off_o,
  output logic             mem_req_o,
  output lanes_t           push_cnt_o,
  output byte_t            push_b0_o,
  output byte_t            push_b1_o
);
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic             take;

  assign mem_req_o  = addr_lsb_i ? (free_i >= CNT_W'(1)) : (free_i >= CNT_W'(BUS_BYTES));
  assign take       = mem_req_o && mem_ack_i && !flush_i;
  assign push_cnt_o = !take ? lanes_t'(0) : (addr_lsb_i ? lanes_t'(1) : lanes_t'(BUS_BYTES));
  // odd byte lives in the upper lane
  assign push_b0_o  = addr_lsb_i ? mem_rdata_i[15:8] : mem_rdata_i[7:0];
  assign push_b1_o  = mem_rdata_i[15:8];
  assign seg_o      = seg_q;
  assign off_o      = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= RST_SEG;
      off_q <= RST_OFF;
    end else if (flush_i) begin
      seg_q <= flush_seg_i;
      off_q <= flush_off_i;
    end else if (take) begin
      off_q <= off_q + OFF_W'(push_cnt_o);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !flush_i |=> mem_req_o && $stable(off_q) && $stable(seg_q)); // R3
endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  lanes_t           push_cnt_i,
  input  byte_t            push_b0_i,
  input  byte_t            push_b1_i,
  input  logic             pop_i,
  output byte_t            head_o,
  output logic [CNT_W-1:0] fill_o,
  output logic [CNT_W-1:0] free_o
);
  byte_t            mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr1, wr2;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr1    = ptr_inc(wr_q);
  assign wr2    = ptr_inc(wr1);
  assign head_o = mem_q[rd_q];
  assign fill_o = cnt_q;
  assign free_o = CNT_W'(DEPTH) - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= (push_cnt_i == lanes_t'(2)) ? wr2 : (push_cnt_i == lanes_t'(1)) ? wr1 : wr_q;
      rd_q  <= pop_i ? ptr_inc(rd_q) : rd_q;
      cnt_q <= cnt_q + CNT_W'(push_cnt_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      if (push_cnt_i != lanes_t'(0)) mem_q[wr_q] <= push_b0_i;
      if (push_cnt_i == lanes_t'(2)) mem_q[wr1]  <= push_b1_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(push_cnt_i) <= free_o); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0); // R7
  AST_PUSH_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i && pop_i && push_cnt_i == lanes_t'(1) |=> cnt_q == $past(cnt_q)); // R9
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned DEPTH = 6,
  parameter logic [SEG_W-1:0] RST_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RST_OFF = 16'h0000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [SEG_W-1:0]       flush_seg_i,
  input  logic [OFF_W-1:0]       flush_off_i,
  output logic                   mem_req_o,
  output logic [SEG_W+SHIFT-1:0] mem_addr_o,
  input  logic                   mem_ack_i,
  input  logic [15:0]            mem_rdata_i,
  output logic                   dec_valid_o,
  output logic [7:0]             dec_byte_o,
  input  logic                   dec_ready_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [CNT_W-1:0] fill, free;
  lanes_t           push_cnt;
  byte_t            push_b0, push_b1, head;
  logic             pop;

  pfq_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_addr (
    .seg_i(seg), .off_i(off), .addr_o(mem_addr_o)
  );

  pfq_fetch_ctrl #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
  ) u_ctrl (
    .clk_i, .rst_ni, .flush_i, .flush_seg_i, .flush_off_i,
    .mem_ack_i, .mem_rdata_i,
    .free_i(free), .addr_lsb_i(mem_addr_o[0]),
    .seg_o(seg), .off_o(off), .mem_req_o,
    .push_cnt_o(push_cnt), .push_b0_o(push_b0), .push_b1_o(push_b1)
  );

  pfq_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i,
    .push_cnt_i(push_cnt), .push_b0_i(push_b0), .push_b1_i(push_b1),
    .pop_i(pop), .head_o(head), .fill_o(fill), .free_o(free)
  );

  assign dec_valid_o = (fill != '0) && !flush_i;
  assign dec_byte_o  = head;
  assign pop         = dec_valid_o && dec_ready_i;

  AST_ROOM_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_addr_o[0] |-> fill <= CNT_W'(DEPTH - 2)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !dec_valid_o); // R8
  AST_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !flush_i |=> !mem_addr_o[0]); // R5
endmodule

// File: tb/pfq_top_tb_top.sv
module pfq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] fseg = '0, foff = '0;
  logic        req, ack = 1'b0, valid, ready = 1'b0;
  logic [19:0] addr;
  logic [15:0] rdata = '0;
  logic [7:0]  dbyte;

  int          n_chk = 0, n_bad = 0, occ = 0, cyc = 0;
  logic [7:0]  exp_q[$];
  string       tag = "R6";
  bit          prev_hold = 0, pend_chk = 0;
  logic [19:0] prev_addr = '0, pend_addr = '0;

  always #5 clk = ~clk;

  pfq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .flush_seg_i(fseg), .flush_off_i(foff),
    .mem_req_o(req), .mem_addr_o(addr), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .dec_valid_o(valid), .dec_byte_o(dbyte), .dec_ready_i(ready)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'b0} + {4'b0, o};
  endfunction

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] + a[15:8] * 8'd7 + {4'b0, a[19:16]} * 8'd29;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // scoreboard driver: expected byte stream from a fetch location
  task automatic load_expected(input logic [15:0] s, input logic [15:0] o, input int n);
    exp_q.delete();
    for (int k = 0; k < n; k++) exp_q.push_back(mbyte(phys(s, o + 16'(k))));
  endtask

  task automatic step(input bit fl, input logic [15:0] s, input logic [15:0] o,
                      input int rdy_pct, input int ack_pct);
    @(negedge clk);
    if (pend_chk) begin
      check(req && addr == pend_addr, "R8", "address after redirect", addr, pend_addr);
      pend_chk = 0;
    end
    if (prev_hold) check(req && addr == prev_addr, "R3", "held request", addr, prev_addr);
    flush = fl; fseg = s; foff = o;
    ack   = fl ? 1'b1 : (int'($urandom_range(99)) < ack_pct);
    rdata = {mbyte({addr[19:1], 1'b1}), mbyte({addr[19:1], 1'b0})};
    ready = int'($urandom_range(99)) < rdy_pct;
    #1;
    check(valid == (occ != 0 && !fl), "R7", "valid vs occupancy", valid, occ);
    if (req) check(occ <= (addr[0] ? 5 : 4), "R3", "request room", occ, addr[0] ? 5 : 4);
    if (fl) begin
      occ = 0;
      load_expected(s, o, 400);
      pend_chk = 1; pend_addr = phys(s, o); prev_hold = 0;
    end else begin
      // monitor: pop and compare
      if (valid && ready) begin
        if (exp_q.size() == 0) check(0, tag, "unexpected byte", dbyte, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(dbyte == e, tag, "byte order/content", dbyte, e);
        end
        occ--;
      end
      if (req && ack) occ += addr[0] ? 1 : 2;
      check(occ >= 0 && occ <= 6, "R7", "occupancy bound", occ, 6);
      prev_hold = req && !ack; prev_addr = addr;
    end
  endtask

  task automatic run(input int n, input int rdy_pct, input int ack_pct);
    for (int i = 0; i < n; i++) step(0, '0, '0, rdy_pct, ack_pct);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", cyc, 50000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!valid, "R1", "valid after reset", valid, 0);
    check(req, "R1", "request after reset", req, 1);
    check(addr == 20'hFFFF0, "R1", "reset address", addr, 20'hFFFF0);
    load_expected(16'hFFFF, 16'h0000, 400);
    // R2/R4/R10: physical wrap from FFFFF to 00000
    tag = "R2/R4/R10";
    run(200, 60, 70);
    // R5: odd start realigns
    tag = "R5/R6";
    step(1, 16'h1234, 16'h0005, 50, 50);
    run(200, 40, 80);
    // R10: pointer wrap inside segment, odd start
    tag = "R10/R5";
    step(1, 16'h1000, 16'hFFFB, 50, 50);
    run(150, 50, 60);
    // R7/R9: fill to capacity, then stream with simultaneous push and pop
    tag = "R9/R7";
    step(1, 16'h0ABC, 16'h0010, 0, 50);
    run(40, 0, 100);
    run(200, 100, 100);
    run(200, 70, 90);
    // R8: redirects in quick succession with acknowledge in the redirect cycle
    tag = "R8/R6";
    step(1, 16'h2000, 16'h0003, 50, 50);
    run(3, 100, 100);
    step(1, 16'h3000, 16'h0100, 50, 50);
    run(150, 50, 50);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule